// File: doc/BRIEF.md
# Core Interrupt Unit

This block collects every interrupt source of a small processor core and turns them into two requests for the pipeline. The first is a maskable interrupt request. The second is a separate non-maskable request that also selects the reset exception vector. The maskable sources fill an 8-bit pending field:

- two software-written bits;
- five sampled hardware lines, one of which this configuration ties inactive;
- a timer bit, raised when a free-running counter reaches a programmed compare value.

An 8-bit mask, a global enable and an exception-level flag qualify the pending field.

The non-maskable input is active-low. It is captured only when a separate strobe rises, and it produces a single-cycle request on the falling edge of the captured level. That request is honoured only while the pipeline is running.

Software reaches the state through a small register port of four words: status, cause, count and compare. Reads are combinational and writes take effect at the clock edge.

Top module: `core_irq_unit`

## Requirements
- R1: After reset:
  - `int_req`, `nmi_req` and `vec_reset` are 0;
  - the status and cause words read 0;
  - count reads 0 and compare reads 0xFFFFFFFF.
- R2: `reg_addr` selects the register:
  - 0 is status: mask in bits [15:8], exception level in bit 1, global enable in bit 0;
  - 1 is cause: pending field in bits [15:8];
  - 2 is count; 3 is compare.
  - Status bits outside those fields read 0 whatever was written.
- R3: `int_req` is high exactly when some pending bit has its mask bit set, the global enable is 1 and the exception level is 0. It follows status writes in the cycle after the write edge.
- R4: `irq_hw[3:0]` appear as pending bits [5:2] one clock after they are sampled and follow the line level. `irq_hw[4]` is ignored and pending bit 6 always reads 0.
- R5: Pending bits [1:0] change only on a cause write, which loads them from `reg_wdata[9:8]`. Cause writes leave pending bits [7:2] unchanged, and no hardware event alters bits [1:0].
- R6: Count increments by one on each clock edge with `count_en` high, wraps from 0xFFFFFFFF to 0, and loads `reg_wdata` on a count write.
- R7: Pending bit 7 is set on the edge after the cycle in which count equals compare, then stays set until a compare write clears it.
- R8: If count equals compare in the same cycle as a compare write, pending bit 7 is set (or stays set) rather than cleared.
- R9: `nmi_n` is captured only on a clock edge where `nmi_strobe` is 1 after being 0 at the previous edge. A 1-to-0 change of the captured level gives a one-cycle `nmi_req` in the cycle after that edge, regardless of mask, global enable or exception level.
- R10: `nmi_req` is produced only while `pipe_run` is 1, and `vec_reset` is high whenever `nmi_req` is.
- R11: Capturing low again while the captured level is already low gives no further `nmi_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq_hw | input | 5 | Hardware interrupt lines, active-high |
| nmi_n | input | 1 | Non-maskable interrupt, active-low |
| nmi_strobe | input | 1 | Capture strobe for `nmi_n` |
| pipe_run | input | 1 | Pipeline running flag |
| count_en | input | 1 | Timer count enable |
| int_req | output | 1 | Maskable interrupt request |
| nmi_req | output | 1 | Non-maskable request pulse |
| vec_reset | output | 1 | Selects the reset exception vector |

## Verification
The results fall due at different distances from their stimulus:

- A status or cause write moves `int_req` and the read data right after its write edge.
- A hardware line reaches the pending field one edge after it is sampled.
- A count/compare equality sets the timer bit one edge after the cycle in which the two registers match.
- An NMI pulse occupies exactly the cycle after the capturing strobe edge.

Every bench task drives its inputs one nanosecond after a rising edge and samples just after the edge at which the result is due. It also samples one cycle earlier where latency matters, to show the value has not moved yet.

// File: rtl/core_irq_pkg.sv
package core_irq_pkg;

    localparam int DATA_W   = 32;
    localparam int SW_W     = 2;
    localparam int HW_W     = 5;
    localparam int PEND_W   = SW_W + HW_W + 1;
    localparam int FIELD_LSB = 8;

    typedef enum logic [1:0] {
        RA_STATUS  = 2'd0,
        RA_CAUSE   = 2'd1,
        RA_COUNT   = 2'd2,
        RA_COMPARE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [PEND_W-1:0] mask;
        logic              exc_lvl;
        logic              glb_en;
    } status_t;

    function automatic logic [DATA_W-1:0] pack_status(status_t s);
        logic [DATA_W-1:0] r;
        r = '0;
        r[FIELD_LSB +: PEND_W] = s.mask;
        r[1] = s.exc_lvl;
        r[0] = s.glb_en;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_cause(logic [PEND_W-1:0] p);
        logic [DATA_W-1:0] r;
        r = '0;
        r[FIELD_LSB +: PEND_W] = p;
        return r;
    endfunction

endpackage

// File: rtl/irq_nmi_cond.sv
module irq_nmi_cond (
    input  logic clk,
    input  logic rst,
    input  logic nmi_n,
    input  logic strobe,
    input  logic pipe_run,
    output logic nmi_req
);
    logic strobe_q;
    logic lvl_q;
    logic lvl_prev;
    logic strobe_rise;

    assign strobe_rise = strobe && !strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            lvl_q    <= 1'b1;
            lvl_prev <= 1'b1;
        end else begin
            strobe_q <= strobe;
            lvl_prev <= lvl_q;
            if (strobe_rise) begin
                lvl_q <= nmi_n;
            end
        end
    end

    // falling edge of the captured active-low level, honoured only while running
    assign nmi_req = lvl_prev && !lvl_q && pipe_run;

endmodule

// File: rtl/irq_timer.sv
module irq_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         count_en,
    input  logic         wr_count,
    input  logic         wr_cmp,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count_q,
    output logic [W-1:0] cmp_q,
    output logic         tpend
);
    logic match;

    assign match = (count_q == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            cmp_q   <= '1;
            tpend   <= 1'b0;
        end else begin
            if (wr_count) begin
                count_q <= wdata;
            end else if (count_en) begin
                count_q <= count_q + W'(1);
            end
            if (wr_cmp) begin
                cmp_q <= wdata;
            end
            // a match wins over the clear that a compare write requests
            if (match) begin
                tpend <= 1'b1;
            end else if (wr_cmp) begin
                tpend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import core_irq_pkg::*;
#(
    parameter logic [HW_W-1:0] HW_LIVE = 5'b01111
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_status,
    input  logic              wr_cause,
    input  logic [PEND_W-1:0] wr_mask,
    input  logic [1:0]        wr_flags,
    input  logic [SW_W-1:0]   wr_sw,
    input  logic [HW_W-1:0]   irq_hw,
    input  logic              tpend,
    output status_t           st,
    output logic [PEND_W-1:0] pend,
    output logic              int_req
);
    logic [SW_W-1:0] sw_q;
    logic [HW_W-1:0] hw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            sw_q <= '0;
            hw_q <= '0;
        end else begin
            hw_q <= irq_hw & HW_LIVE;
            if (wr_status) begin
                st.mask    <= wr_mask;
                st.exc_lvl <= wr_flags[1];
                st.glb_en  <= wr_flags[0];
            end
            if (wr_cause) begin
                sw_q <= wr_sw;
            end
        end
    end

    assign pend    = {tpend, hw_q, sw_q};
    assign int_req = (|(pend & st.mask)) && st.glb_en && !st.exc_lvl;

endmodule

// File: rtl/core_irq_unit.sv
module core_irq_unit
    import core_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [HW_W-1:0]   irq_hw,
    input  logic              nmi_n,
    input  logic              nmi_strobe,
    input  logic              pipe_run,
    input  logic              count_en,
    output logic              int_req,
    output logic              nmi_req,
    output logic              vec_reset
);
    reg_addr_e         sel;
    logic              status_wr;
    logic              cause_wr;
    logic              count_wr;
    logic              cmp_wr;
    status_t           st;
    logic [PEND_W-1:0] pend;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] cmp_q;
    logic              tpend;

    assign sel       = reg_addr_e'(reg_addr);
    assign status_wr = reg_wr && (sel == RA_STATUS);
    assign cause_wr  = reg_wr && (sel == RA_CAUSE);
    assign count_wr  = reg_wr && (sel == RA_COUNT);
    assign cmp_wr    = reg_wr && (sel == RA_COMPARE);

    irq_timer #(.W(DATA_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .count_en (count_en),
        .wr_count (count_wr),
        .wr_cmp   (cmp_wr),
        .wdata    (reg_wdata),
        .count_q  (count_q),
        .cmp_q    (cmp_q),
        .tpend    (tpend)
    );

    irq_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_status (status_wr),
        .wr_cause  (cause_wr),
        .wr_mask   (reg_wdata[FIELD_LSB +: PEND_W]),
        .wr_flags  (reg_wdata[1:0]),
        .wr_sw     (reg_wdata[FIELD_LSB +: SW_W]),
        .irq_hw    (irq_hw),
        .tpend     (tpend),
        .st        (st),
        .pend      (pend),
        .int_req   (int_req)
    );

    irq_nmi_cond u_nmi (
        .clk      (clk),
        .rst      (rst),
        .nmi_n    (nmi_n),
        .strobe   (nmi_strobe),
        .pipe_run (pipe_run),
        .nmi_req  (nmi_req)
    );

    assign vec_reset = nmi_req;

    always_comb begin
        case (sel)
            RA_STATUS: reg_rdata = pack_status(st);
            RA_CAUSE:  reg_rdata = pack_cause(pend);
            RA_COUNT:  reg_rdata = count_q;
            default:   reg_rdata = cmp_q;
        endcase
    end

endmodule

// File: rtl/irq_checker.sv
module irq_checker (
    input logic        clk,
    input logic        rst,
    input logic        nmi_n,
    input logic        nmi_strobe,
    input logic        pipe_run,
    input logic        nmi_req,
    input logic        int_req,
    input logic [7:0]  pend,
    input logic        gie,
    input logic        exc,
    input logic        cause_wr,
    input logic [31:0] count_q,
    input logic [31:0] cmp_q
);
    // R3: request only with global enable set and exception level clear
    a_r3_req_qualified: assert property (@(posedge clk) disable iff (rst)
        int_req |-> (gie && !exc));

    // R4: pending bit 6 is never raised
    a_r4_bit6_quiet: assert property (@(posedge clk) disable iff (rst)
        !pend[6]);

    // R5: software bits only move on a cause write
    a_r5_sw_hold: assert property (@(posedge clk) disable iff (rst)
        !cause_wr |=> $stable(pend[1:0]));

    // R7: equality sets the timer bit on the next edge
    a_r7_match_sets: assert property (@(posedge clk) disable iff (rst)
        (count_q == cmp_q) |=> pend[7]);

    // R9: a request follows a low capture at a strobe edge
    a_r9_nmi_source: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> ($past(nmi_strobe) && !$past(nmi_n)));

    // R10: no request while the pipeline is stopped
    a_r10_nmi_running: assert property (@(posedge clk) disable iff (rst)
        nmi_req |-> pipe_run);

    // R11: a request lasts a single cycle
    a_r11_nmi_single: assert property (@(posedge clk) disable iff (rst)
        nmi_req |=> !nmi_req);

endmodule

bind core_irq_unit irq_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .nmi_n      (nmi_n),
    .nmi_strobe (nmi_strobe),
    .pipe_run   (pipe_run),
    .nmi_req    (nmi_req),
    .int_req    (int_req),
    .pend       (pend),
    .gie        (st.glb_en),
    .exc        (st.exc_lvl),
    .cause_wr   (cause_wr),
    .count_q    (count_q),
    .cmp_q      (cmp_q)
);

// File: tb/test_core_irq_unit.sv
`timescale 1ns/1ps
module test_core_irq_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  irq_hw = '0;
    logic        nmi_n = 1'b1;
    logic        nmi_strobe = 1'b0;
    logic        pipe_run = 1'b0;
    logic        count_en = 1'b0;
    logic        int_req;
    logic        nmi_req;
    logic        vec_reset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    core_irq_unit i_core_irq_unit (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_hw     (irq_hw),
        .nmi_n      (nmi_n),
        .nmi_strobe (nmi_strobe),
        .pipe_run   (pipe_run),
        .count_en   (count_en),
        .int_req    (int_req),
        .nmi_req    (nmi_req),
        .vec_reset  (vec_reset)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
    endtask

    task automatic strobe_pulse();
        nmi_strobe = 1'b0;
        tick();
        nmi_strobe = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 int_req", {31'd0, int_req}, 32'd0);
        chk("R1 nmi_req", {31'd0, nmi_req}, 32'd0);
        chk("R1 vec_reset", {31'd0, vec_reset}, 32'd0);
        rd(2'd0, d); chk("R1 status", d, 32'd0);
        rd(2'd1, d); chk("R1 cause", d, 32'd0);
        rd(2'd2, d); chk("R1 count", d, 32'd0);
        rd(2'd3, d); chk("R1 compare", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(2'd0, 32'hFFFF_AB03);
        rd(2'd0, d); chk("R2 status fields", d, 32'h0000_AB03);
        wr(2'd0, 32'h0000_00FC);
        rd(2'd0, d); chk("R2 status spare bits", d, 32'd0);
    endtask

    task automatic t_sw();
        logic [31:0] d;
        wr(2'd1, 32'hFFFF_FF00);
        rd(2'd1, d); chk("R5 cause only low pending", d, 32'h0000_0300);
        chk("R3 masked off", {31'd0, int_req}, 32'd0);
        wr(2'd0, 32'h0000_0101);
        chk("R3 mask+enable", {31'd0, int_req}, 32'd1);
        wr(2'd0, 32'h0000_0103);
        chk("R3 exception level blocks", {31'd0, int_req}, 32'd0);
        wr(2'd0, 32'h0000_0100);
        chk("R3 global enable off", {31'd0, int_req}, 32'd0);
        wr(2'd0, 32'h0000_0201);
        chk("R3 bit1 mask", {31'd0, int_req}, 32'd1);
        irq_hw = 5'b00000;
        repeat (3) tick();
        rd(2'd1, d); chk("R5 hold without write", d, 32'h0000_0300);
        wr(2'd1, 32'h0000_0000);
        rd(2'd1, d); chk("R5 cleared by write", d, 32'd0);
        chk("R3 nothing pending", {31'd0, int_req}, 32'd0);
    endtask

    task automatic t_hw();
        logic [31:0] d;
        wr(2'd0, 32'h0000_FF01);
        irq_hw = 5'b10000;
        tick(); tick();
        rd(2'd1, d); chk("R4 line4 ignored", d, 32'd0);
        chk("R4 line4 no request", {31'd0, int_req}, 32'd0);
        irq_hw = 5'b00101;
        rd(2'd1, d); chk("R4 not before edge", d, 32'd0);
        tick();
        rd(2'd1, d); chk("R4 lines to bits 2 and 4", d, 32'h0000_1400);
        chk("R4 request", {31'd0, int_req}, 32'd1);
        wr(2'd1, 32'h0000_0000);
        rd(2'd1, d); chk("R5 cause write keeps hw bits", d, 32'h0000_1400);
        irq_hw = 5'b11000;
        tick();
        rd(2'd1, d); chk("R4 level follow", d, 32'h0000_2000);
        irq_hw = 5'b00000;
        tick();
        rd(2'd1, d); chk("R4 released", d, 32'd0);
        wr(2'd0, 32'h0000_0000);
    endtask

    task automatic t_count();
        logic [31:0] d;
        wr(2'd2, 32'd10);
        rd(2'd2, d); chk("R6 count load", d, 32'd10);
        count_en = 1'b1;
        repeat (5) tick();
        count_en = 1'b0;
        rd(2'd2, d); chk("R6 count +5", d, 32'd15);
        tick();
        rd(2'd2, d); chk("R6 hold when disabled", d, 32'd15);
        wr(2'd2, 32'hFFFF_FFFE);
        count_en = 1'b1;
        repeat (3) tick();
        count_en = 1'b0;
        rd(2'd2, d); chk("R6 wrap", d, 32'd1);
        rd(2'd1, d); chk("R7 set passing compare", d, 32'h0000_8000);
        wr(2'd3, 32'h0000_0100);
        rd(2'd1, d); chk("R7 compare write clears", d, 32'd0);
    endtask

    task automatic t_timer();
        logic [31:0] d;
        wr(2'd2, 32'd57);
        wr(2'd3, 32'd60);
        count_en = 1'b1;
        repeat (3) tick();
        rd(2'd1, d); chk("R7 not yet at equality", d, 32'd0);
        tick();
        count_en = 1'b0;
        rd(2'd1, d); chk("R7 set edge after equality", d, 32'h0000_8000);
        repeat (3) tick();
        rd(2'd1, d); chk("R7 sticky", d, 32'h0000_8000);
        wr(2'd0, 32'h0000_8001);
        chk("R3 timer request", {31'd0, int_req}, 32'd1);
        wr(2'd3, 32'd200);
        rd(2'd1, d); chk("R7 cleared", d, 32'd0);
        chk("R3 request dropped", {31'd0, int_req}, 32'd0);
        wr(2'd0, 32'h0000_0000);
    endtask

    task automatic t_same();
        logic [31:0] d;
        wr(2'd2, 32'd5);
        wr(2'd3, 32'd5);
        tick();
        rd(2'd1, d); chk("R7 equal set", d, 32'h0000_8000);
        wr(2'd3, 32'd9);
        rd(2'd1, d); chk("R8 match beats clear", d, 32'h0000_8000);
        tick();
        rd(2'd1, d); chk("R8 still set", d, 32'h0000_8000);
        wr(2'd3, 32'd20);
        rd(2'd1, d); chk("R8 later write clears", d, 32'd0);
    endtask

    task automatic t_nmi();
        pipe_run = 1'b1;
        nmi_n = 1'b0;
        tick(); tick();
        chk("R9 no capture without strobe", {31'd0, nmi_req}, 32'd0);
        nmi_strobe = 1'b1;
        tick();
        chk("R9 pulse", {31'd0, nmi_req}, 32'd1);
        chk("R10 vector select", {31'd0, vec_reset}, 32'd1);
        tick();
        chk("R9 one cycle", {31'd0, nmi_req}, 32'd0);
        strobe_pulse();
        chk("R11 no repeat while low", {31'd0, nmi_req}, 32'd0);
        nmi_n = 1'b1;
        strobe_pulse();
        chk("R9 rising capture silent", {31'd0, nmi_req}, 32'd0);
        pipe_run = 1'b0;
        nmi_n = 1'b0;
        strobe_pulse();
        chk("R10 stopped pipeline", {31'd0, nmi_req}, 32'd0);
        chk("R10 no vector", {31'd0, vec_reset}, 32'd0);
        nmi_n = 1'b1;
        strobe_pulse();
        pipe_run = 1'b1;
        wr(2'd0, 32'h0000_FF02);
        nmi_n = 1'b0;
        strobe_pulse();
        chk("R9 unmaskable", {31'd0, nmi_req}, 32'd1);
        chk("R3 maskable stays low", {31'd0, int_req}, 32'd0);
        tick();
        nmi_strobe = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_regs();
        t_sw();
        t_hw();
        t_count();
        t_timer();
        t_same();
        t_nmi();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule